// File: doc/BRIEF.md
# Nth-Burst Read-Data Capture

This block snoops a 64-bit memory read-data path for debug. Software picks a command ordinal and a burst ordinal within that command. The block counts read commands as they are issued. It follows the returning data beats, command by command, and counts the beats inside each command. The first beat whose command ordinal and beat ordinal both equal the programmed values is copied into a 64-bit capture store. Software reads that store back as two 32-bit read-only words.

A frame-start pulse re-arms the snooper. It zeroes the command and beat counts and drops the sticky "already captured" state. The capture store keeps its old contents until a new match in the new frame overwrites it. Selectors and captured data go through a small single-cycle write port with a combinational read port.

Top module: `burst_snoop`

## Requirements
- R1: After reset, all four register addresses read as zero: 0 = command selector, 1 = burst selector, 2 = captured bits [31:0], 3 = captured bits [63:32].
- R2: A write to address 0 stores write-data bits [15:0] as the command selector. A write to address 1 stores bits [5:0] as the burst selector. On read-back the unused upper bits return zero.
- R3: A frame-start pulse zeroes the issued-command count, the completed-command count and the beat ordinal, and clears the captured state. A beat or issue strobe in the same cycle is ignored. The capture store is not changed by the pulse.
- R4: An accepted beat captures its 64-bit data when both ordinals match. The command ordinal must equal the command selector, where 0 is the first command after frame start. The beat ordinal must equal the burst selector, where 0 is the first beat of that command. The data reads back at address 2 (bits [31:0]) and address 3 (bits [63:32]) from the cycle after the beat.
- R5: A beat with the last marker set belongs to its own command and ends it. The next accepted beat is beat 0 of the following command. A burst selector beyond the length of the selected command captures nothing. The beat ordinal saturates at 63 and does not wrap.
- R6: Once a capture has happened, no later match changes the capture store until the next frame start.
- R7: Writes to addresses 2 and 3 have no effect on the values read there.
- R8: A beat is accepted only while at least one issued command has not yet completed, counting issues from earlier cycles. Any other beat is ignored: it is not counted and it is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that re-arms the capture for a new frame |
| cmd_issue | input | 1 | One read command issued this cycle |
| beat_valid | input | 1 | A read-data beat is present this cycle |
| beat_last | input | 1 | The present beat is the final beat of its command |
| beat_data | input | 64 | Read-data beat |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that data returns in issue order. They also assume each command ends with exactly one beat carrying the last marker, and that at most one command is issued per cycle. The completed-count bound only holds because beats without an outstanding command are dropped. The stimulus issues every command before its beats, or sends stray beats on purpose to exercise the drop rule. It drives all inputs on the falling edge and holds each strobe for one full cycle. Frame-start pulses are placed both alone and on top of a beat, so the clearing priority is exercised without breaking the ordering assumption.

// File: rtl/burst_snoop_pkg.sv
// Package: shared register address map for the read-data snooper.
// Assumes a two-bit register address; all four codes are used.
package burst_snoop_pkg;

    typedef enum logic [1:0] {
        SEL_CMD   = 2'd0,
        SEL_BURST = 2'd1,
        CAP_LO    = 2'd2,
        CAP_HI    = 2'd3
    } snoop_reg_e;

endpackage

// File: rtl/burst_snoop_regs.sv
// Module: burst_snoop_regs
// Holds the command and burst selectors and serves the read mux.
// Assumes single-cycle writes; reads are combinational from the address.
// The capture store is read-only here; writes to its addresses are dropped.
module burst_snoop_regs
    import burst_snoop_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int CMD_W   = 16,
    parameter int BURST_W = 6,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [DATA_W-1:0]  cap_data,
    output logic [CMD_W-1:0]   cmd_sel,
    output logic [BURST_W-1:0] burst_sel,
    output logic [REG_W-1:0]   reg_rdata
);

    logic unused_wdata;
    assign unused_wdata = &{1'b0, reg_wdata[REG_W-1:CMD_W]};

    // Selector storage: loaded by writes to their own addresses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sel   <= '0;
            burst_sel <= '0;
        end else if (reg_wr) begin
            case (snoop_reg_e'(reg_addr))
                SEL_CMD:   cmd_sel   <= reg_wdata[CMD_W-1:0];
                SEL_BURST: burst_sel <= reg_wdata[BURST_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read mux: zero-extends the selectors and splits the capture store.
    always_comb begin
        reg_rdata = '0;
        case (snoop_reg_e'(reg_addr))
            SEL_CMD:   reg_rdata[CMD_W-1:0]   = cmd_sel;
            SEL_BURST: reg_rdata[BURST_W-1:0] = burst_sel;
            CAP_LO:    reg_rdata              = cap_data[REG_W-1:0];
            CAP_HI:    reg_rdata              = cap_data[DATA_W-1:REG_W];
            default:   reg_rdata              = '0;
        endcase
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(cmd_sel) && $stable(burst_sel))); // R2

endmodule

// File: rtl/burst_snoop_track.sv
// Module: burst_snoop_track
// Counts issued and completed commands and the beat ordinal inside the
// command currently returning data, and flags the beat that matches both
// selectors. Assumes in-order data return with one last-marked beat per
// command. Counters saturate instead of wrapping.
module burst_snoop_track #(
    parameter int CMD_W   = 16,
    parameter int BURST_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               cmd_issue,
    input  logic               beat_valid,
    input  logic               beat_last,
    input  logic [CMD_W-1:0]   cmd_sel,
    input  logic [BURST_W-1:0] burst_sel,
    output logic               hit
);

    localparam int CNT_W = CMD_W + 1;
    localparam logic [CNT_W-1:0]   CNT_MAX  = '1;
    localparam logic [BURST_W-1:0] BEAT_MAX = '1;

    logic [CNT_W-1:0]   issue_cnt;
    logic [CNT_W-1:0]   resp_cnt;
    logic [BURST_W-1:0] beat_cnt;
    logic               outstanding;
    logic               beat_ok;

    // Beat acceptance: needs an earlier-issued command still open.
    always_comb begin
        outstanding = (issue_cnt > resp_cnt);
        beat_ok     = beat_valid && !frame_start && outstanding;
    end

    // Issued-command counter: cleared by frame start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            issue_cnt <= '0;
        end else if (cmd_issue && (issue_cnt != CNT_MAX)) begin
            issue_cnt <= issue_cnt + 1'b1;
        end
    end

    // Completed-command counter: the ordinal of the command now returning.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            resp_cnt <= '0;
        end else if (beat_ok && beat_last && (resp_cnt != CNT_MAX)) begin
            resp_cnt <= resp_cnt + 1'b1;
        end
    end

    // Beat ordinal: restarts after a last beat, holds at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            beat_cnt <= '0;
        end else if (beat_ok) begin
            if (beat_last) begin
                beat_cnt <= '0;
            end else if (beat_cnt != BEAT_MAX) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
        end
    end

    // Match detector: both ordinals equal their selectors.
    always_comb begin
        hit = beat_ok && (resp_cnt == {1'b0, cmd_sel}) && (beat_cnt == burst_sel);
    end

    AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (issue_cnt == '0 && resp_cnt == '0 && beat_cnt == '0)); // R3

    AST_RESP_LE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_cnt <= issue_cnt); // R8

    AST_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !outstanding && !frame_start)
        |=> ($stable(beat_cnt) && $stable(resp_cnt))); // R8

    AST_BEAT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && !beat_last && beat_cnt == BEAT_MAX) |=> (beat_cnt == BEAT_MAX)); // R5

    AST_LAST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && beat_last) |=> (beat_cnt == '0)); // R5

endmodule

// File: rtl/burst_snoop_cap.sv
// Module: burst_snoop_cap
// Stores the matching beat once per frame behind a sticky flag.
// Assumes the match input is already suppressed during frame start.
// Frame start clears the flag but keeps the stored data.
module burst_snoop_cap #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              hit,
    input  logic [DATA_W-1:0] beat_data,
    output logic [DATA_W-1:0] cap_data,
    output logic              captured
);

    logic take;

    // Capture enable: first match of the frame only.
    always_comb begin
        take = hit && !captured && !frame_start;
    end

    // Sticky flag: set on the capture, dropped on frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            captured <= 1'b0;
        end else if (take) begin
            captured <= 1'b1;
        end
    end

    // Capture store: loaded only by the enabled match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data <= '0;
        end else if (take) begin
            cap_data <= beat_data;
        end
    end

    AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !captured && !frame_start)
        |=> (captured && cap_data == $past(beat_data))); // R4

    AST_CAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        captured |=> $stable(cap_data)); // R6

    AST_FRAME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> $stable(cap_data)); // R3

endmodule

// File: rtl/burst_snoop.sv
// Module: burst_snoop (top)
// Debug snooper on a read-data path: captures the beat selected by a
// command ordinal and a beat ordinal, once per frame.
// Assumes in-order return, one last-marked beat per command and at most
// one command issue per cycle. All state resets to zero.
module burst_snoop #(
    parameter int REG_W   = 32,
    parameter int CMD_W   = 16,
    parameter int BURST_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 cmd_issue,
    input  logic                 beat_valid,
    input  logic                 beat_last,
    input  logic [2*REG_W-1:0]   beat_data,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata
);

    localparam int DATA_W = 2 * REG_W;

    logic [CMD_W-1:0]   cmd_sel;
    logic [BURST_W-1:0] burst_sel;
    logic [DATA_W-1:0]  cap_data;
    logic               hit;
    logic               captured;

    burst_snoop_regs #(
        .REG_W   (REG_W),
        .CMD_W   (CMD_W),
        .BURST_W (BURST_W),
        .DATA_W  (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cap_data  (cap_data),
        .cmd_sel   (cmd_sel),
        .burst_sel (burst_sel),
        .reg_rdata (reg_rdata)
    );

    burst_snoop_track #(
        .CMD_W   (CMD_W),
        .BURST_W (BURST_W)
    ) i_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cmd_issue   (cmd_issue),
        .beat_valid  (beat_valid),
        .beat_last   (beat_last),
        .cmd_sel     (cmd_sel),
        .burst_sel   (burst_sel),
        .hit         (hit)
    );

    burst_snoop_cap #(
        .DATA_W (DATA_W)
    ) i_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .hit         (hit),
        .beat_data   (beat_data),
        .cap_data    (cap_data),
        .captured    (captured)
    );

    AST_HIT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !frame_start); // R3

endmodule

// File: tb/test_burst_snoop.sv
// Scoreboard bench: the driver pushes expected register reads into a queue
// and a monitor pops and compares them against reg_rdata.
module test_burst_snoop;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        cmd_issue = 1'b0;
    logic        beat_valid = 1'b0;
    logic        beat_last = 1'b0;
    logic [63:0] beat_data = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    burst_snoop i_burst_snoop (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cmd_issue   (cmd_issue),
        .beat_valid  (beat_valid),
        .beat_last   (beat_last),
        .beat_data   (beat_data),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    function automatic logic [63:0] mk(input int c, input int b);
        logic [7:0] c8;
        logic [7:0] b8;
        c8 = c[7:0];
        b8 = b[7:0];
        return {16'hC0DE, c8, b8, 16'hBEEF, c8 ^ 8'h5A, b8};
    endfunction

    // Monitor: compares one expected read per cycle, after the edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                total++;
                if (reg_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h",
                             it.tag, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.addr = a;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic issue();
        cmd_issue = 1'b1;
        @(negedge clk);
        cmd_issue = 1'b0;
    endtask

    task automatic beat(input logic [63:0] d, input logic last);
        beat_valid = 1'b1;
        beat_data = d;
        beat_last = last;
        @(negedge clk);
        beat_valid = 1'b0;
        beat_last = 1'b0;
    endtask

    task automatic frame_beat(input logic [63:0] d);
        frame_start = 1'b1;
        beat_valid = 1'b1;
        beat_data = d;
        @(negedge clk);
        frame_start = 1'b0;
        beat_valid = 1'b0;
    endtask

    // Sends one command's beats, last marker on the final one.
    task automatic burst(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            beat(mk(c, i), (i == n - 1));
        end
    endtask

    initial begin
        logic [63:0] want;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero after reset
        chk(2'd0, 32'h0, "R1 cmd selector");
        chk(2'd1, 32'h0, "R1 burst selector");
        chk(2'd2, 32'h0, "R1 capture low");
        chk(2'd3, 32'h0, "R1 capture high");

        // R2: selector widths on read-back
        wr(2'd0, 32'hFFFF_1234);
        chk(2'd0, 32'h0000_1234, "R2 cmd selector");
        wr(2'd1, 32'hFFFF_FFC5);
        chk(2'd1, 32'h0000_0005, "R2 burst selector");

        // R4 and R5: command 1, beat 2, after a four-beat command 0
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd2);
        frame();
        issue(); issue(); issue();
        burst(0, 4);
        burst(1, 4);
        want = mk(1, 2);
        chk(2'd2, want[31:0], "R4 capture low");
        chk(2'd3, want[63:32], "R4 R5 capture high");

        // R6: a later match in the same frame does not overwrite
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd0);
        burst(2, 2);
        chk(2'd2, want[31:0], "R6 capture low");
        chk(2'd3, want[63:32], "R6 capture high");

        // R7: writes to capture addresses are dropped
        wr(2'd2, 32'hDEAD_BEEF);
        wr(2'd3, 32'hFEED_F00D);
        chk(2'd2, want[31:0], "R7 capture low");
        chk(2'd3, want[63:32], "R7 capture high");

        // R3: frame start keeps data; a beat under frame start is ignored
        wr(2'd0, 32'd0);
        frame();
        chk(2'd2, want[31:0], "R3 capture kept");
        issue();
        frame_beat(mk(9, 9));
        issue();
        beat(mk(3, 0), 1'b1);
        want = mk(3, 0);
        chk(2'd2, want[31:0], "R3 capture low");
        chk(2'd3, want[63:32], "R3 capture high");

        // R8: a beat without an outstanding command is ignored
        frame();
        beat(mk(4, 4), 1'b1);
        issue();
        beat(mk(5, 0), 1'b1);
        want = mk(5, 0);
        chk(2'd2, want[31:0], "R8 capture low");
        chk(2'd3, want[63:32], "R8 capture high");

        // R5: burst selector past the end of the command captures nothing
        wr(2'd1, 32'd3);
        frame();
        issue(); issue();
        burst(6, 2);
        burst(7, 4);
        chk(2'd2, want[31:0], "R5 short command low");
        chk(2'd3, want[63:32], "R5 short command high");

        // R5: first beat after a last beat is beat 0 of the next command
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd0);
        frame();
        issue(); issue();
        burst(6, 2);
        burst(8, 3);
        want = mk(8, 0);
        chk(2'd2, want[31:0], "R5 next command low");
        chk(2'd3, want[63:32], "R5 next command high");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule